// File: doc/BRIEF.md
# Predicated Tile Row Accumulator

This block keeps a square byte array of `VL_BYTES` storage rows, each `VL_BYTES` bytes wide. The array holds several integer tiles that are interleaved row by row. A command picks one tile, an element width of 32 or 64 bits, a source vector, a row predicate and a column predicate. The block then adds the vector into that tile, one tile row per clock cycle. In the across-row form, each active row adds the whole vector element by element. In the broadcast form, each active row takes the single vector element whose index equals the row number and adds it into every active column of that row.

Commands enter through a valid/ready handshake. `cmd_ready` is high exactly when the block is idle. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. A requester facing low `cmd_ready` keeps `cmd_valid` and its fields steady, and the command is taken on the first edge where `cmd_ready` is high. This includes the cycle in which `done` pulses. The storage can also be reached through a plain row write port and a plain registered row read port. These ports are used to load tiles and to read back results.

Top module: `tile_row_accum`

## Requirements
- R1: In across-row mode (`cmd_vert`=0), tile element (row, col) gains source element col when that row and that column are both active.
- R2: In broadcast mode (`cmd_vert`=1), tile element (row, col) gains source element row when that row and that column are both active.
- R3: `cmd_wide`=0 selects 32-bit elements and `cmd_wide`=1 selects 64-bit elements. A row holds N = VL_BYTES/E elements, where E is the element size in bytes, and a tile has N rows. Source element k occupies vector bits [k*8E +: 8E]. With 32-bit elements, only `cmd_tile[1:0]` selects the tile and `cmd_tile[2]` is ignored.
- R4: Row r is active when `cmd_prow[r*E]` is set, and column c is active when `cmd_pcol[c*E]` is set. All other predicate bits have no effect.
- R5: Row r of tile t is stored in storage row t + E*r. Element c of a storage row occupies bits [c*8E +: 8E].
- R6: Each sum wraps modulo 2^(8E). A carry never crosses from one element into the next. In 64-bit mode, a carry passes from the low 32-bit half of an element into its high half.
- R7: Elements in inactive rows or inactive columns, and every storage row outside the selected tile, keep their values.
- R8: After a command is accepted, `cmd_ready` stays low for exactly N cycles, one per tile row, including inactive rows. `done` then pulses high for one cycle, in the same cycle that `cmd_ready` returns high. A command held valid through that cycle is accepted on the next edge.
- R9: All command fields are captured at acceptance. Changes to these fields while the block is busy have no effect on the running command.
- R10: When `st_we` is high and the block is idle, `st_wdata` is written to storage row `st_waddr`. When the block is busy, `st_we` is ignored. `st_rdata` shows storage row `st_raddr` as it stood one rising edge earlier.
- R11: While reset is low, every storage row clears to zero, `cmd_ready` goes high, `done` goes low and `st_rdata` clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle; command accepted when both high |
| cmd_vert | input | 1 | 0 = add vector across row, 1 = broadcast one element per row |
| cmd_wide | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| cmd_tile | input | 3 | Tile number |
| cmd_vec | input | VL_BYTES*8 | Source vector |
| cmd_prow | input | VL_BYTES | Row predicate |
| cmd_pcol | input | VL_BYTES | Column predicate |
| done | output | 1 | One-cycle pulse when a command completes |
| st_we | input | 1 | Storage row write enable (ignored while busy) |
| st_waddr | input | log2(VL_BYTES) | Storage row to write |
| st_wdata | input | VL_BYTES*8 | Storage row write data |
| st_raddr | input | log2(VL_BYTES) | Storage row to read |
| st_rdata | output | VL_BYTES*8 | Registered storage row read data |

## Verification
Several properties are checked on every cycle:
- Every engine write address keeps the tile number in its low bits, as the interleaved layout requires.
- No engine write occurs while the block is idle.
- The row counter stays below the tile height.
- `done` lasts one cycle and appears only when the busy interval ends.
- The two halves of a 64-bit element are always enabled together.

The bench scenarios cover what those properties cannot see. They check the actual sums, including wraparound and the carry between halves. They confirm that off-group predicate bits and the unused tile bit are ignored, that fields changed in flight are not picked up, that writes landing while busy are dropped, and that a command held valid is taken back to back.

// File: rtl/tra_pkg.sv
package tra_pkg;

  // Direction of the accumulate.
  typedef enum logic {
    DIR_ROWVEC = 1'b0,
    DIR_BCAST  = 1'b1
  } acc_dir_e;

  // Element width.
  typedef enum logic {
    EW32 = 1'b0,
    EW64 = 1'b1
  } elem_w_e;

  // Captured command controls.
  typedef struct packed {
    acc_dir_e    dir;
    elem_w_e     ew;
    logic [2:0]  tile;
  } acc_ctl_t;

endpackage

// File: rtl/tra_seq.sv
// Row sequencer: one tile row per busy cycle, done pulse at the end.
module tra_seq
  import tra_pkg::*;
#(
  parameter int VL_BYTES = 16,
  parameter int IDX_W    = $clog2(VL_BYTES / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  elem_w_e          ew,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] row_idx
);

  localparam int ROWS32 = VL_BYTES / 4;
  localparam int ROWS64 = VL_BYTES / 8;

  logic [IDX_W-1:0] last_idx;

  always_comb begin
    last_idx = (ew == EW64) ? IDX_W'(ROWS64 - 1) : IDX_W'(ROWS32 - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      row_idx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        row_idx <= '0;
      end else if (busy) begin
        if (row_idx == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          row_idx <= row_idx + 1'b1;
        end
      end
    end
  end

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(row_idx) < ((ew == EW64) ? ROWS64 : ROWS32)));

endmodule

// File: rtl/tra_operand.sv
// Builds the per-lane addend and the per-lane column enables for the current row.
module tra_operand
  import tra_pkg::*;
#(
  parameter int VL_BYTES = 16,
  parameter int IDX_W    = $clog2(VL_BYTES / 4)
) (
  input  acc_dir_e                  dir,
  input  elem_w_e                   ew,
  input  logic [VL_BYTES*8-1:0]     vec,
  input  logic [VL_BYTES/4-1:0]     pcb,      // column predicate, one bit per 32-bit lane
  input  logic [IDX_W-1:0]          row_idx,
  output logic [VL_BYTES*8-1:0]     addend,
  output logic [VL_BYTES/4-1:0]     lane_en
);

  localparam int LANES32 = VL_BYTES / 4;
  localparam int LANES64 = VL_BYTES / 8;

  logic [31:0] sel32;
  logic [63:0] sel64;

  // Pick the element indexed by the row number for the broadcast form.
  always_comb begin
    sel32 = '0;
    for (int k = 0; k < LANES32; k++) begin
      if (int'(row_idx) == k) sel32 = vec[k*32 +: 32];
    end
    sel64 = '0;
    for (int k = 0; k < LANES64; k++) begin
      if (int'(row_idx) == k) sel64 = vec[k*64 +: 64];
    end
  end

  for (genvar j = 0; j < LANES32; j++) begin : g_lane
    logic [31:0] bc_word;
    if (j % 2 == 0) begin : g_lo
      assign bc_word = (ew == EW64) ? sel64[31:0] : sel32;
    end else begin : g_hi
      assign bc_word = (ew == EW64) ? sel64[63:32] : sel32;
    end
    assign addend[j*32 +: 32] = (dir == DIR_BCAST) ? bc_word : vec[j*32 +: 32];
    assign lane_en[j] = (ew == EW64) ? pcb[(j/2)*2] : pcb[j];
  end

endmodule

// File: rtl/tra_adder.sv
// Row adder built from 32-bit lanes; the carry joins lane pairs in 64-bit mode.
module tra_adder
  import tra_pkg::*;
#(
  parameter int VL_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  elem_w_e               ew,
  input  logic [VL_BYTES*8-1:0] old_row,
  input  logic [VL_BYTES*8-1:0] addend,
  input  logic [VL_BYTES/4-1:0] lane_en,
  output logic [VL_BYTES*8-1:0] new_row
);

  localparam int LANES64 = VL_BYTES / 8;

  for (genvar p = 0; p < LANES64; p++) begin : g_pair
    logic [32:0] lo_sum;
    logic        cin;
    logic [31:0] hi_sum;

    assign lo_sum = {1'b0, old_row[p*64 +: 32]} + {1'b0, addend[p*64 +: 32]};
    assign cin    = (ew == EW64) & lo_sum[32];
    assign hi_sum = old_row[p*64+32 +: 32] + addend[p*64+32 +: 32] + {31'd0, cin};

    assign new_row[p*64 +: 32]    = lane_en[2*p]   ? lo_sum[31:0] : old_row[p*64 +: 32];
    assign new_row[p*64+32 +: 32] = lane_en[2*p+1] ? hi_sum       : old_row[p*64+32 +: 32];

    // R6
    pair_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ew == EW64) |-> (lane_en[2*p] == lane_en[2*p+1]));
  end

endmodule

// File: rtl/tra_store.sv
// Flop array of storage rows with one engine port and one plain port.
module tra_store #(
  parameter int VL_BYTES = 16,
  parameter int VL_BITS  = VL_BYTES * 8,
  parameter int AW       = $clog2(VL_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               eng_we,
  input  logic [AW-1:0]      eng_addr,
  input  logic [VL_BITS-1:0] eng_wdata,
  output logic [VL_BITS-1:0] eng_rdata,
  input  logic               ext_we,
  input  logic [AW-1:0]      ext_waddr,
  input  logic [VL_BITS-1:0] ext_wdata,
  input  logic [AW-1:0]      ext_raddr,
  output logic [VL_BITS-1:0] ext_rdata
);

  localparam int NROWS = VL_BYTES;

  logic [VL_BITS-1:0] rows [NROWS];

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic [VL_BITS-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (eng_we && eng_addr == AW'(r)) begin
        q <= eng_wdata;
      end else if (ext_we && !busy && ext_waddr == AW'(r)) begin
        q <= ext_wdata;
      end
    end
    assign rows[r] = q;
  end

  assign eng_rdata = rows[eng_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_rdata <= '0;
    else        ext_rdata <= rows[ext_raddr];
  end

endmodule

// File: rtl/tile_row_accum.sv
// Predicated tile accumulator over interleaved row storage.
module tile_row_accum
  import tra_pkg::*;
#(
  parameter  int VL_BYTES = 16,
  localparam int VL_BITS  = VL_BYTES * 8,
  localparam int AW       = $clog2(VL_BYTES),
  localparam int IDX_W    = $clog2(VL_BYTES / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_vert,
  input  logic               cmd_wide,
  input  logic [2:0]         cmd_tile,
  input  logic [VL_BITS-1:0] cmd_vec,
  input  logic [VL_BYTES-1:0] cmd_prow,
  input  logic [VL_BYTES-1:0] cmd_pcol,
  output logic               done,
  input  logic               st_we,
  input  logic [AW-1:0]      st_waddr,
  input  logic [VL_BITS-1:0] st_wdata,
  input  logic [AW-1:0]      st_raddr,
  output logic [VL_BITS-1:0] st_rdata
);

  localparam int LANES32 = VL_BYTES / 4;
  localparam int ROWS32  = VL_BYTES / 4;
  localparam int ROWS64  = VL_BYTES / 8;

  logic                 busy;
  logic                 accept;
  logic [IDX_W-1:0]     row_idx;
  acc_ctl_t             ctl_q;
  logic [VL_BITS-1:0]   vec_q;
  logic [LANES32-1:0]   prb_q;
  logic [LANES32-1:0]   pcb_q;
  logic [LANES32-1:0]   prb_in;
  logic [LANES32-1:0]   pcb_in;
  logic                 unused_pred;

  logic                 act32, act64, row_act;
  logic [2:0]           tile_eff;
  logic [AW-1:0]        eng_addr;
  logic                 eng_we;
  logic [VL_BITS-1:0]   old_row, new_row, addend;
  logic [LANES32-1:0]   lane_en;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  // Only the lowest predicate bit of each 32-bit group matters.
  for (genvar k = 0; k < LANES32; k++) begin : g_pred
    assign prb_in[k] = cmd_prow[k*4];
    assign pcb_in[k] = cmd_pcol[k*4];
  end
  assign unused_pred = ^{cmd_prow, cmd_pcol};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      vec_q <= '0;
      prb_q <= '0;
      pcb_q <= '0;
    end else if (accept) begin
      ctl_q <= '{dir: acc_dir_e'(cmd_vert), ew: elem_w_e'(cmd_wide), tile: cmd_tile};
      vec_q <= cmd_vec;
      prb_q <= prb_in;
      pcb_q <= pcb_in;
    end
  end

  tra_seq #(.VL_BYTES(VL_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .ew      (ctl_q.ew),
    .busy    (busy),
    .done    (done),
    .row_idx (row_idx)
  );

  // Row activity and storage address of the current tile row.
  always_comb begin
    act32 = 1'b0;
    for (int k = 0; k < ROWS32; k++) begin
      if (int'(row_idx) == k) act32 = prb_q[k];
    end
    act64 = 1'b0;
    for (int k = 0; k < ROWS64; k++) begin
      if (int'(row_idx) == k) act64 = prb_q[2*k];
    end
    row_act  = (ctl_q.ew == EW64) ? act64 : act32;
    tile_eff = (ctl_q.ew == EW64) ? ctl_q.tile : {1'b0, ctl_q.tile[1:0]};
    eng_addr = AW'(tile_eff) +
               ((ctl_q.ew == EW64) ? (AW'(row_idx) << 3) : (AW'(row_idx) << 2));
  end

  assign eng_we = busy && row_act;

  tra_operand #(.VL_BYTES(VL_BYTES), .IDX_W(IDX_W)) u_opnd (
    .dir     (ctl_q.dir),
    .ew      (ctl_q.ew),
    .vec     (vec_q),
    .pcb     (pcb_q),
    .row_idx (row_idx),
    .addend  (addend),
    .lane_en (lane_en)
  );

  tra_adder #(.VL_BYTES(VL_BYTES)) u_add (
    .clk     (clk),
    .rst_n   (rst_n),
    .ew      (ctl_q.ew),
    .old_row (old_row),
    .addend  (addend),
    .lane_en (lane_en),
    .new_row (new_row)
  );

  tra_store #(.VL_BYTES(VL_BYTES), .VL_BITS(VL_BITS), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (new_row),
    .eng_rdata (old_row),
    .ext_we    (st_we),
    .ext_waddr (st_waddr),
    .ext_wdata (st_wdata),
    .ext_raddr (st_raddr),
    .ext_rdata (st_rdata)
  );

  // R5
  interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((ctl_q.ew == EW64) ? (eng_addr[2:0] == ctl_q.tile)
                                 : (eng_addr[1:0] == ctl_q.tile[1:0])));

  // R7
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_we);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

endmodule

// File: tb/sim_tile_row_accum.sv
module sim_tile_row_accum;

  localparam int CLK_PERIOD = 10;
  localparam int VLB    = 16;
  localparam int VLBITS = VLB * 8;
  localparam int NT     = 8;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic              cmd_vert;
  logic              cmd_wide;
  logic [2:0]        cmd_tile;
  logic [VLBITS-1:0] cmd_vec;
  logic [VLB-1:0]    cmd_prow;
  logic [VLB-1:0]    cmd_pcol;
  logic              done;
  logic              st_we;
  logic [3:0]        st_waddr;
  logic [VLBITS-1:0] st_wdata;
  logic [3:0]        st_raddr;
  logic [VLBITS-1:0] st_rdata;

  int total = 0;
  int bad   = 0;
  logic [VLBITS-1:0] mdl [VLB];

  tile_row_accum #(.VL_BYTES(VLB)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vert(cmd_vert), .cmd_wide(cmd_wide), .cmd_tile(cmd_tile),
    .cmd_vec(cmd_vec), .cmd_prow(cmd_prow), .cmd_pcol(cmd_pcol), .done(done),
    .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
    .st_raddr(st_raddr), .st_rdata(st_rdata)
  );

  // {vert, wide, tile, vec, prow, pcol}
  localparam logic [164:0] TBL [NT] = '{
    {1'b0, 1'b0, 3'd1, 128'h00000004_00000003_00000002_00000001, 16'hFFFF, 16'hFFFF},
    {1'b1, 1'b0, 3'd2, 128'h00000028_0000001E_00000014_0000000A, 16'h0F0F, 16'h0111},
    {1'b0, 1'b1, 3'd3, 128'h00000000_00000001_00000000_FFFFFFFF, 16'h0101, 16'h00FF},
    {1'b1, 1'b1, 3'd5, 128'h00000002_00000000_FFFFFFFF_FFFFFFFF, 16'hFFFF, 16'hFFFF},
    {1'b0, 1'b0, 3'd4, 128'h00000005_00000006_00000007_00000008, 16'hEEEE, 16'hFFFF},
    {1'b1, 1'b0, 3'd0, 128'h00000100_00000200_00000300_00000400, 16'h1001, 16'h1000},
    {1'b0, 1'b1, 3'd7, 128'h80000000_00000000_00000000_00000005, 16'h0100, 16'h0100},
    {1'b1, 1'b1, 3'd0, 128'h00000000_00000009_00000000_00000007, 16'h0001, 16'hFFFE}
  };

  string tags [NT] = '{
    "R1 R5 R6 R9", "R2 R4 R7 R9", "R1 R3 R6 R9", "R2 R3 R6 R9",
    "R3 R4 R7 R9", "R2 R4 R7 R9", "R1 R5 R6 R9", "R2 R4 R7 R9"
  };

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VLBITS-1:0] act, input logic [VLBITS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_apply(input logic v, input logic w, input logic [2:0] t,
                             input logic [VLBITS-1:0] vec,
                             input logic [VLB-1:0] pr, input logic [VLB-1:0] pc);
    int e;
    int n;
    int tb;
    e  = w ? 8 : 4;
    n  = VLB / e;
    tb = w ? int'(t) : int'(t[1:0]);
    for (int r = 0; r < n; r++) begin
      if (pr[r*e]) begin
        int s;
        s = tb + e * r;
        for (int c = 0; c < n; c++) begin
          if (pc[c*e]) begin
            if (w) begin
              logic [63:0] a64;
              a64 = v ? vec[r*64 +: 64] : vec[c*64 +: 64];
              mdl[s][c*64 +: 64] = mdl[s][c*64 +: 64] + a64;
            end else begin
              logic [31:0] a32;
              a32 = v ? vec[r*32 +: 32] : vec[c*32 +: 32];
              mdl[s][c*32 +: 32] = mdl[s][c*32 +: 32] + a32;
            end
          end
        end
      end
    end
  endtask

  task automatic wr_row(input int s, input logic [VLBITS-1:0] d);
    st_we    = 1'b1;
    st_waddr = 4'(s);
    st_wdata = d;
    @(negedge clk);
    st_we    = 1'b0;
    mdl[s]   = d;
  endtask

  task automatic rd_row(input int s, output logic [VLBITS-1:0] d);
    st_raddr = 4'(s);
    @(negedge clk);
    d = st_rdata;
  endtask

  task automatic cmp_all(input string req, input string what);
    bit ok;
    logic [VLBITS-1:0] d, fa, fe;
    ok = 1'b1;
    fa = '0;
    fe = '0;
    for (int s = 0; s < VLB; s++) begin
      rd_row(s, d);
      if (d !== mdl[s] && ok) begin
        ok = 1'b0;
        fa = d;
        fe = mdl[s];
      end
    end
    chk(ok, req, what, fa, fe);
  endtask

  task automatic run_cmd(input logic v, input logic w, input logic [2:0] t,
                         input logic [VLBITS-1:0] vec,
                         input logic [VLB-1:0] pr, input logic [VLB-1:0] pc);
    int cnt;
    int expn;
    expn      = w ? VLB/8 : VLB/4;
    cmd_vert  = v;
    cmd_wide  = w;
    cmd_tile  = t;
    cmd_vec   = vec;
    cmd_prow  = pr;
    cmd_pcol  = pc;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R9: scramble every field while the command runs
    cmd_valid = 1'b0;
    cmd_vert  = ~v;
    cmd_wide  = ~w;
    cmd_tile  = t + 3'd1;
    cmd_vec   = ~vec;
    cmd_prow  = ~pr;
    cmd_pcol  = ~pc;
    cnt = 0;
    while (!cmd_ready) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == expn, "R8", "busy cycle count", VLBITS'(cnt), VLBITS'(expn));
    chk(done === 1'b1, "R8", "done at end", VLBITS'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R8", "done width", VLBITS'(done), 0);
    model_apply(v, w, t, vec, pr, pc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [164:0]      e;
    logic [VLBITS-1:0] d;
    logic [VLBITS-1:0] pat;
    int c1;
    int c2;

    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_vert  = 1'b0;
    cmd_wide  = 1'b0;
    cmd_tile  = 3'd0;
    cmd_vec   = '0;
    cmd_prow  = '0;
    cmd_pcol  = '0;
    st_we     = 1'b0;
    st_waddr  = '0;
    st_wdata  = '0;
    st_raddr  = 4'd5;
    for (int s = 0; s < VLB; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk(cmd_ready === 1'b1, "R11", "ready in reset", VLBITS'(cmd_ready), 1);
    chk(done === 1'b0, "R11", "done in reset", VLBITS'(done), 0);
    chk(st_rdata === '0, "R11", "read data in reset", st_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_row(5, d);
    chk(d === '0, "R11", "storage cleared", d, '0);

    // Preload storage through the plain write port
    for (int s = 0; s < VLB; s++) begin
      for (int c = 0; c < VLB/4; c++) pat[c*32 +: 32] = 32'((s*16 + c) * 32'h01010101);
      if (s == 1) pat = '1;
      wr_row(s, pat);
    end
    // R10: registered read returns written row
    rd_row(7, d);
    chk(d === mdl[7], "R10", "read after idle write", d, mdl[7]);

    // Table walk
    for (int i = 0; i < NT; i++) begin
      e = TBL[i];
      run_cmd(e[164], e[163], e[162:160], e[159:32], e[31:16], e[15:0]);
      cmp_all(tags[i], $sformatf("table entry %0d", i));
    end

    // R10: write during busy is dropped (row 2 lies outside tile 0)
    cmd_vert  = 1'b0;
    cmd_wide  = 1'b0;
    cmd_tile  = 3'd0;
    cmd_vec   = {4{32'd1}};
    cmd_prow  = 16'hFFFF;
    cmd_pcol  = 16'hFFFF;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    st_we     = 1'b1;
    st_waddr  = 4'd2;
    st_wdata  = {4{32'hDEADBEEF}};
    @(negedge clk);
    st_we     = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    model_apply(1'b0, 1'b0, 3'd0, {4{32'd1}}, 16'hFFFF, 16'hFFFF);
    cmp_all("R10", "write while busy ignored");

    // R8: valid held high, second command taken when ready returns
    cmd_vert  = 1'b1;
    cmd_wide  = 1'b1;
    cmd_tile  = 3'd6;
    cmd_vec   = {64'd3, 64'd2};
    cmd_prow  = 16'hFFFF;
    cmd_pcol  = 16'hFFFF;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c1 = 0;
    while (!cmd_ready) begin
      c1++;
      @(negedge clk);
    end
    chk(done === 1'b1, "R8", "done with ready back", VLBITS'(done), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    c2 = 0;
    while (!cmd_ready) begin
      c2++;
      @(negedge clk);
    end
    chk(c1 == 2 && c2 == 2, "R8", "back-to-back busy counts",
        VLBITS'(c1 * 16 + c2), VLBITS'(2 * 16 + 2));
    @(negedge clk);
    model_apply(1'b1, 1'b1, 3'd6, {64'd3, 64'd2}, 16'hFFFF, 16'hFFFF);
    model_apply(1'b1, 1'b1, 3'd6, {64'd3, 64'd2}, 16'hFFFF, 16'hFFFF);
    cmp_all("R8", "held valid applied twice");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule